// File: doc/BRIEF.md
# Shared Machine Timer with Per-Hart Compare

This block keeps one free-running 64-bit time counter and one 64-bit compare value for each of a small, parameterised number of harts. Each hart gets its own level-sensitive machine-timer interrupt line. The line is high whenever the counter has reached that hart's compare value. A companion core-local interrupt path carries the line to the hart.

Software reaches the registers over a 32-bit register bus. The bus carries a word address within the block's 32 KiB window. The platform chooses where that window sits, so the block decodes only the offset. Each 64-bit register is split into a low and a high word. The counter advances on cycles where a tick-enable input is high, and the tick source lives outside the block.

Top module: `mtimer_unit`

## Requirements
- R1: After reset the counter reads zero, every existing compare register reads all ones (0xFFFFFFFF in both halves), and every interrupt line is low.
- R2: The compare value of hart n is at byte offset 8·n (word address 2·n) with its low word there and its high word at byte offset 8·n+4 (word address 2·n+1).
- R3: The counter's low word is at byte offset 0x7ff8 (word address 0x1FFE) and its high word at 0x7ffc (word address 0x1FFF).
- R4: The counter increments by one, wrapping modulo 2^64, on every clock where tick_en is high and no counter write occurs; otherwise it holds.
- R5: A bus write to either counter word replaces that word and suppresses the increment for that cycle, leaving the other word unchanged.
- R6: timer_irq[n] is high exactly while the counter is unsigned greater than or equal to hart n's compare value, equality included.
- R7: A write to one 32-bit half of a compare register leaves its other half unchanged, and the interrupt reflects the new value from the following cycle.
- R8: Reads of compare words for hart indices at or above NUM_HARTS, and of any other unmapped word, return zero; writes there change no register.
- R9: bus_ready is high in exactly the cycles where bus_valid is high; bus_rdata carries the addressed word as it was before any update in that cycle, and is zero when bus_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advance the counter this cycle |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Word address within the window (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, pre-update contents |
| bus_ready | output | 1 | Access accepted this cycle |
| timer_irq | output | NUM_HARTS | Per-hart machine-timer interrupt level |

## Verification
The bench builds the block with NUM_HARTS set to 3, so hart indices 0 to 2 are backed by registers and hart 3's compare words fall in the unmapped space. With that setting the bench can check the zero-read and ignored-write rule right next to the last real compare register. Three harts also let one compare sit below the counter, one sit above it and one equal it at the same time, so each interrupt line is checked against its own threshold. The counter is written close to 2^64 so that the wrap and the drop of every interrupt line fall within a short run.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int WORD_W = 32;
  localparam int REG_W  = 64;
  localparam int ADDR_W = 13;
  localparam logic [ADDR_W-1:0] CNT_LO_WORD = 13'h1FFE;
  localparam logic [ADDR_W-1:0] CNT_HI_WORD = 13'h1FFF;

  // Replace one 32-bit half of a 64-bit register.
  function automatic logic [REG_W-1:0] merge_half(input logic [REG_W-1:0] old_val,
                                                  input logic [WORD_W-1:0] wdata,
                                                  input logic hi);
    logic [REG_W-1:0] v;
    v = old_val;
    if (hi) v[REG_W-1:WORD_W] = wdata;
    else    v[WORD_W-1:0]     = wdata;
    return v;
  endfunction

  // Select one 32-bit half of a 64-bit register.
  function automatic logic [WORD_W-1:0] pick_half(input logic [REG_W-1:0] val,
                                                  input logic hi);
    return hi ? val[REG_W-1:WORD_W] : val[WORD_W-1:0];
  endfunction

  // Interrupt condition: counter reached the compare value (unsigned).
  function automatic logic reached(input logic [REG_W-1:0] cnt,
                                   input logic [REG_W-1:0] cmp);
    return cnt >= cmp;
  endfunction
endpackage

// File: rtl/mtimer_decode.sv
module mtimer_decode
  import mtimer_pkg::*;
#(
  parameter int NUM_HARTS = 2
) (
  input  logic                 valid,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 cnt_sel,
  output logic [NUM_HARTS-1:0] cmp_sel,
  output logic                 half_hi,
  output logic                 hit_none
);
  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0] reg_idx;
  assign reg_idx = addr[ADDR_W-1:1];
  assign half_hi = addr[0];
  assign cnt_sel = valid && (addr[ADDR_W-1:1] == CNT_LO_WORD[ADDR_W-1:1]);

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_sel
    assign cmp_sel[h] = valid && (reg_idx == IDX_W'(h));
  end

  assign hit_none = valid && !cnt_sel && (cmp_sel == '0);
endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter
  import mtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic [REG_W-1:0]  cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (wr_en)    cnt_q <= merge_half(cnt_q, wdata, wr_hi);
    else if (tick_en)  cnt_q <= cnt_q + REG_W'(1);
  end
endmodule

// File: rtl/mtimer_cmp_bank.sv
module mtimer_cmp_bank
  import mtimer_pkg::*;
#(
  parameter int NUM_HARTS = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_HARTS-1:0]            wr_en,
  input  logic                            wr_hi,
  input  logic [WORD_W-1:0]               wdata,
  input  logic [REG_W-1:0]                cnt,
  output logic [NUM_HARTS-1:0][REG_W-1:0] cmp_q,
  output logic [NUM_HARTS-1:0]            irq
);
  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cmp_q[h] <= '1;
      else if (wr_en[h]) cmp_q[h] <= merge_half(cmp_q[h], wdata, wr_hi);
    end
    assign irq[h] = reached(cnt, cmp_q[h]);
  end
endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit
  import mtimer_pkg::*;
#(
  parameter int NUM_HARTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [12:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_ready,
  output logic [NUM_HARTS-1:0] timer_irq
);
  logic                            cnt_sel;
  logic [NUM_HARTS-1:0]            cmp_sel;
  logic                            half_hi;
  logic                            hit_none;
  logic                            cnt_wr;
  logic [NUM_HARTS-1:0]            cmp_wr;
  logic [REG_W-1:0]                cnt_q;
  logic [NUM_HARTS-1:0][REG_W-1:0] cmp_q;

  mtimer_decode #(.NUM_HARTS(NUM_HARTS)) u_dec (
    .valid(bus_valid), .addr(bus_addr), .cnt_sel(cnt_sel),
    .cmp_sel(cmp_sel), .half_hi(half_hi), .hit_none(hit_none)
  );

  assign cnt_wr = cnt_sel && bus_write;
  assign cmp_wr = cmp_sel & {NUM_HARTS{bus_write}};

  mtimer_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(cnt_wr),
    .wr_hi(half_hi), .wdata(bus_wdata), .cnt_q(cnt_q)
  );

  mtimer_cmp_bank #(.NUM_HARTS(NUM_HARTS)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_en(cmp_wr), .wr_hi(half_hi),
    .wdata(bus_wdata), .cnt(cnt_q), .cmp_q(cmp_q), .irq(timer_irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (!hit_none) begin
      if (cnt_sel) bus_rdata = pick_half(cnt_q, half_hi);
      for (int h = 0; h < NUM_HARTS; h++)
        if (cmp_sel[h]) bus_rdata = pick_half(cmp_q[h], half_hi);
    end
  end

  assign bus_ready = bus_valid;
endmodule

// File: rtl/mtimer_unit_chk.sv
module mtimer_unit_chk #(
  parameter int NUM_HARTS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick_en,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic                 bus_ready,
  input logic                 cnt_wr,
  input logic                 half_hi,
  input logic                 hit_none,
  input logic [NUM_HARTS-1:0] cmp_wr,
  input logic [63:0]          cnt_q,
  input logic [63:0]          cmp0_q,
  input logic [NUM_HARTS-1:0] timer_irq
);
  AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 64'd1)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr) |=> $stable(cnt_q)); // R4
  AST_CNT_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !half_hi) |=> (cnt_q[31:0] == $past(bus_wdata)) && (cnt_q[63:32] == $past(cnt_q[63:32]))); // R5
  AST_CNT_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && half_hi) |=> (cnt_q[63:32] == $past(bus_wdata)) && (cnt_q[31:0] == $past(cnt_q[31:0]))); // R5
  AST_IRQ_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_irq[0] && !(bus_valid && bus_write) && !(tick_en && cnt_q == '1)) |=> timer_irq[0]); // R6
  AST_CMP_OTHER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr[0] && !half_hi) |=> (cmp0_q[63:32] == $past(cmp0_q[63:32]))); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit_none |-> (bus_rdata == 32'd0)); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (!bus_ready && bus_rdata == 32'd0)); // R9
endmodule

bind mtimer_unit mtimer_unit_chk #(.NUM_HARTS(NUM_HARTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_ready(bus_ready), .cnt_wr(cnt_wr), .half_hi(half_hi),
  .hit_none(hit_none), .cmp_wr(cmp_wr), .cnt_q(cnt_q), .cmp0_q(cmp_q[0]),
  .timer_irq(timer_irq)
);

// File: tb/mtimer_unit_tb.sv
module mtimer_unit_tb;
  localparam int NH = 3;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          tick_en = 0;
  logic          bus_valid = 0;
  logic          bus_write = 0;
  logic [12:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_ready;
  logic [NH-1:0] timer_irq;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  longint unsigned m_cnt;
  longint unsigned m_cmp[NH];

  always #2.5 clk = ~clk;

  mtimer_unit #(.NUM_HARTS(NH)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .timer_irq(timer_irq)
  );

  task automatic check(string tag, string what, longint unsigned got, longint unsigned exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Expected read word from the model (byte offset = 4*word address).
  function automatic longint unsigned model_read(logic [12:0] a);
    int idx;
    longint unsigned v;
    idx = int'(a >> 1);
    if (a[12:1] == 12'hFFF) v = m_cnt;
    else if (idx < NH) v = m_cmp[idx];
    else return 0;
    return a[0] ? (v >> 32) : (v & 64'hFFFF_FFFF);
  endfunction

  // One bus cycle, called at a falling edge; checks every output, then models the rising edge.
  task automatic cyc(string tag, bit v, bit w, logic [12:0] a, logic [31:0] d, bit t);
    bit cnt_w;
    int idx;
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; tick_en = t;
    #1;
    check("R9", "ready", bus_ready, v);
    check(tag, "rdata", bus_rdata, v ? model_read(a) : 0);
    for (int h = 0; h < NH; h++)
      check("R6", $sformatf("irq[%0d]", h), timer_irq[h], m_cnt >= m_cmp[h]);
    @(posedge clk);
    cnt_w = v && w && (a[12:1] == 12'hFFF);
    idx = int'(a >> 1);
    if (cnt_w) begin
      if (a[0]) m_cnt = {d, m_cnt[31:0]};
      else      m_cnt = {m_cnt[63:32], d};
    end else if (t) m_cnt = m_cnt + 1;
    if (v && w && !cnt_w && idx < NH) begin
      if (a[0]) m_cmp[idx] = {d, m_cmp[idx][31:0]};
      else      m_cmp[idx] = {m_cmp[idx][63:32], d};
    end
    @(negedge clk);
  endtask

  task automatic rd(string tag, logic [12:0] a);
    cyc(tag, 1, 0, a, 32'h0, 0);
  endtask

  task automatic wr(string tag, logic [12:0] a, logic [31:0] d);
    cyc(tag, 1, 1, a, d, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_cnt = 0;
    for (int h = 0; h < NH; h++) m_cmp[h] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset contents
    check("R1", "irq at reset", timer_irq, 0);
    rd("R1", 13'h1FFE); rd("R1", 13'h1FFF);
    for (int h = 0; h < NH; h++) begin rd("R1", 13'(2*h)); rd("R1", 13'(2*h+1)); end

    // R4: ticking and idle
    for (int i = 0; i < 10; i++) cyc("R4", 0, 0, 13'h0, 32'h0, i % 3 != 0);
    rd("R3", 13'h1FFE); rd("R3", 13'h1FFF);
    for (int i = 0; i < 4; i++) cyc("R9", 1, 0, 13'h1FFE, 32'h0, 1); // read during tick

    // R2/R7: hart 0 compare, low half first
    wr("R7", 13'h0000, 32'd20);
    rd("R7", 13'h0001);
    wr("R2", 13'h0001, 32'd0);
    for (int i = 0; i < 16; i++) cyc("R6", 0, 0, 13'h0, 32'h0, 1);
    // hart 1 above counter, hart 2 equal to counter
    wr("R2", 13'h0003, 32'd0);
    wr("R2", 13'h0002, 32'd1000);
    wr("R2", 13'h0005, 32'd0);
    wr("R6", 13'h0004, 32'(m_cnt));
    rd("R6", 13'h0004);
    cyc("R6", 0, 0, 13'h0, 32'h0, 0);

    // R5: counter writes override ticking
    cyc("R5", 1, 1, 13'h1FFE, 32'h0000_0100, 1);
    rd("R5", 13'h1FFE);
    cyc("R5", 1, 1, 13'h1FFF, 32'h0000_0002, 1);
    rd("R5", 13'h1FFF); rd("R5", 13'h1FFE);

    // R4/R6: wrap near 2^64
    wr("R4", 13'h1FFF, 32'hFFFF_FFFF);
    wr("R4", 13'h1FFE, 32'hFFFF_FFFE);
    for (int i = 0; i < 4; i++) cyc("R4", 0, 0, 13'h0, 32'h0, 1);
    rd("R4", 13'h1FFE); rd("R4", 13'h1FFF);

    // R8: nonexistent hart 3 and other holes
    wr("R8", 13'h0006, 32'h0000_0001);
    wr("R8", 13'h0007, 32'h0000_0000);
    rd("R8", 13'h0006); rd("R8", 13'h0007);
    wr("R8", 13'h1000, 32'hDEAD_BEEF);
    rd("R8", 13'h1000); rd("R8", 13'h1FFD);
    for (int h = 0; h < NH; h++) begin rd("R8", 13'(2*h)); rd("R8", 13'(2*h+1)); end
    rd("R8", 13'h1FFE);
    cyc("R9", 0, 1, 13'h0000, 32'h0, 0); // write without valid
    rd("R9", 13'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule